// File: doc/BRIEF.md
# In-Flight Address Conflict Checker

This block decides whether a new request may be issued or must wait, because one of its target addresses is already in flight. A request carries between one and a fixed maximum number of target addresses. The block compares them against the stored slot addresses of a group of command sets. The group is a contiguous run of set indices, given by a first index and a count. A set takes part in the comparison only while it is not free. Inside such a set, only the slots whose enable bit is set are compared.

The stored addresses stay outside the block. The block reads them through a registered read port, one slot per cycle: it presents a set index, a slot index and a read strobe, and the addressed value comes back on the next cycle. The scan stops at the first equality and reports busy. If the scan runs through the whole group without a match, it reports accept. Either verdict comes with a one-cycle done strobe. A request whose address count is outside the legal range is rejected at once, and no read is made for it.

Top module: `inflight_conflict_check`

## Requirements
- R1: After reset, `done_o`, `busy_o`, `bad_o` and `rd_en` are all 0.
- R2: A scan visits set indices `grp_base` to `grp_base+grp_count-1` in ascending order, one step per cycle. A free set costs one cycle and makes no read. A set that is not free costs one cycle per slot, slot 0 first. In each of these cycles `rd_en` is 1, with `rd_set`/`rd_slot` naming the slot, exactly when that slot's enable bit is 1. The enable bit for set s, slot k, is bit `s*SLOTS+k` of `slot_enable`.
- R3: No read is ever made of a set outside the selected group, so a matching address stored there has no effect on the verdict.
- R4: A set is free when its `set_inuse` bit is 0 and its `set_idle` bit is 1. With any other combination of the two bits, the set is scanned.
- R5: A read made in cycle t returns on `rd_addr` in cycle t+1. If that value equals any counted request address, `done_o` is 1 in cycle t+2 with `busy_o`=1 and `bad_o`=0, and no read follows in that cycle.
- R6: If no compared slot matches and the scan took T cycles (T=0 for an empty group), `done_o` is 1 in cycle T+2 after the start edge, with `busy_o`=0 and `bad_o`=0.
- R7: A start with `req_count` of 0 or above `MAX_REQ` gives `done_o`=1, `bad_o`=1 and `busy_o`=0 in the first cycle after the start edge, with no reads.
- R8: A `start` pulse that arrives while a scan is in progress is ignored, and the scan continues unchanged.
- R9: Request address i is taken from bits `[i*ADDR_W +: ADDR_W]` of `req_addr`. Only entries with i < `req_count` are compared.
- R10: `done_o` is high for exactly one cycle per accepted or rejected start. The cycle after it shows `done_o`=0 and `rd_en`=0 unless a new start arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a check; sampled only while idle |
| grp_base | input | $clog2(NUM_SETS) | First set index of the group |
| grp_count | input | $clog2(NUM_SETS)+1 | Number of sets in the group |
| req_count | input | $clog2(MAX_REQ+1) | Number of valid request addresses |
| req_addr | input | MAX_REQ*ADDR_W | Request addresses, entry i at bits i*ADDR_W |
| set_inuse | input | NUM_SETS | Software in-use flag per set |
| set_idle | input | NUM_SETS | Hardware idle status per set |
| slot_enable | input | NUM_SETS*SLOTS | Command-enable bit per slot |
| rd_en | output | 1 | Read strobe for the slot address store |
| rd_set | output | $clog2(NUM_SETS) | Set index being read |
| rd_slot | output | $clog2(SLOTS) | Slot index being read |
| rd_addr | input | ADDR_W | Slot address, valid the cycle after rd_en |
| done_o | output | 1 | One-cycle verdict strobe |
| busy_o | output | 1 | Conflict found (valid with done_o, then held) |
| bad_o | output | 1 | Request count illegal (valid with done_o, then held) |

## Verification
The verdict timing depends on the scan. A rejected request is decided one cycle after the start edge. An accepted request is decided T+2 cycles after the start edge, where T is the number of scan cycles. A conflict is decided two cycles after the read that returns the matching address. The bench holds a behavioural model that walks the group and builds, for each cycle after the start edge, the expected read strobe, the set and slot, and the cycle of the done strobe. It samples on every falling edge and compares all of these, so each result is checked in the exact cycle it is due. It also checks the cycle after done to confirm the strobe drops and no read follows.

// File: rtl/ifc_pkg.sv
`timescale 1ns/1ps
// Shared types of the in-flight conflict checker.
package ifc_pkg;
    // Controller state: waiting for a start, or walking the group.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_t;
endpackage

// File: rtl/scan_cursor.sv
`timescale 1ns/1ps
// scan_cursor: walks a group of sets slot by slot.
// Does: holds the group base and count latched at load, and moves
//   (set offset, slot) forward by one step when asked. When skip_set
//   is high it jumps past the rest of the current set at once.
// Assumes: SLOTS >= 2. A group that runs past the last set index wraps
//   around to set 0.
module scan_cursor #(
    parameter int NUM_SETS = 8,
    parameter int SLOTS    = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic [$clog2(NUM_SETS)-1:0] base,
    input  logic [$clog2(NUM_SETS):0]   count,
    input  logic                        step,
    input  logic                        skip_set,
    output logic [$clog2(NUM_SETS)-1:0] cur_set,
    output logic [$clog2(SLOTS)-1:0]    cur_slot,
    output logic                        exhausted
);
    localparam int SET_W  = $clog2(NUM_SETS);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int CNT_W  = SET_W + 1;

    logic [SET_W-1:0]  base_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  off_q;
    logic [SLOT_W-1:0] slot_q;
    logic              last_slot;
    logic [SET_W-1:0]  rel_set;

    assign last_slot = (slot_q == SLOT_W'(SLOTS - 1));
    assign exhausted = (off_q >= cnt_q);
    assign cur_set   = base_q + off_q[SET_W-1:0];
    assign cur_slot  = slot_q;
    assign rel_set   = cur_set - base_q;

    // Latch the group on load, then advance one slot or one whole set per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
            off_q  <= '0;
            slot_q <= '0;
        end else if (load) begin
            base_q <= base;
            cnt_q  <= count;
            off_q  <= '0;
            slot_q <= '0;
        end else if (step && !exhausted) begin
            if (skip_set || last_slot) begin
                off_q  <= off_q + CNT_W'(1);
                slot_q <= '0;
            end else begin
                slot_q <= slot_q + SLOT_W'(1);
            end
        end
    end

    // The cursor never points outside the latched group while it is live.
    assert_cursor_in_group_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !exhausted |-> ({1'b0, rel_set} < cnt_q));
endmodule

// File: rtl/req_addr_match.sv
`timescale 1ns/1ps
// req_addr_match: compares one stored address with the request list.
// Does: raises hit when probe equals any of the first req_n entries.
// Assumes: entry i sits at bits [i*ADDR_W +: ADDR_W] of reqs.
module req_addr_match #(
    parameter int ADDR_W  = 16,
    parameter int MAX_REQ = 4
) (
    input  logic [ADDR_W-1:0]          probe,
    input  logic [MAX_REQ*ADDR_W-1:0]  reqs,
    input  logic [$clog2(MAX_REQ+1)-1:0] req_n,
    output logic                       hit
);
    localparam int CW = $clog2(MAX_REQ + 1);

    logic [MAX_REQ-1:0] eq;

    // One comparator per request entry, masked by the valid count.
    for (genvar i = 0; i < MAX_REQ; i++) begin : g_cmp
        assign eq[i] = (reqs[i*ADDR_W +: ADDR_W] == probe) && (CW'(i) < req_n);
    end

    assign hit = |eq;
endmodule

// File: rtl/inflight_conflict_check.sv
`timescale 1ns/1ps
// inflight_conflict_check: decides whether a request clashes with
// an address that is still in flight.
// Does: on an accepted start, latches the request addresses and walks
//   the selected group of sets. Free sets are skipped. For each set that
//   is not free, enabled slots are read through a registered port and
//   their addresses compared. The scan ends on the first match (busy) or
//   at the end of the group (accept), and pulses done_o for one cycle.
// Assumes: rd_addr carries the slot named in the previous cycle's read,
//   and the set status inputs stay steady during a scan.
module inflight_conflict_check
    import ifc_pkg::*;
#(
    parameter int NUM_SETS = 8,
    parameter int SLOTS    = 4,
    parameter int ADDR_W   = 16,
    parameter int MAX_REQ  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [$clog2(NUM_SETS)-1:0]   grp_base,
    input  logic [$clog2(NUM_SETS):0]     grp_count,
    input  logic [$clog2(MAX_REQ+1)-1:0]  req_count,
    input  logic [MAX_REQ*ADDR_W-1:0]     req_addr,
    input  logic [NUM_SETS-1:0]           set_inuse,
    input  logic [NUM_SETS-1:0]           set_idle,
    input  logic [NUM_SETS*SLOTS-1:0]     slot_enable,
    output logic                          rd_en,
    output logic [$clog2(NUM_SETS)-1:0]   rd_set,
    output logic [$clog2(SLOTS)-1:0]      rd_slot,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic                          done_o,
    output logic                          busy_o,
    output logic                          bad_o
);
    localparam int SET_W  = $clog2(NUM_SETS);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int CW     = $clog2(MAX_REQ + 1);

    scan_state_t               state_q;
    logic [MAX_REQ*ADDR_W-1:0] req_q;
    logic [CW-1:0]             reqn_q;
    logic                      pend_q;
    logic                      done_q, busy_q, bad_q;

    logic             req_ok, accept_start, load, scanning;
    logic [SET_W-1:0] cur_set;
    logic [SLOT_W-1:0] cur_slot;
    logic             exhausted, set_free, match, hit, finish;
    logic [SLOTS-1:0] en_row;

    assign req_ok       = (req_count != '0) && (req_count <= CW'(MAX_REQ));
    assign accept_start = (state_q == ST_IDLE) && start;
    assign load         = accept_start && req_ok;
    assign scanning     = (state_q == ST_SCAN);

    scan_cursor #(.NUM_SETS(NUM_SETS), .SLOTS(SLOTS)) u_cursor (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .base      (grp_base),
        .count     (grp_count),
        .step      (scanning),
        .skip_set  (set_free),
        .cur_set   (cur_set),
        .cur_slot  (cur_slot),
        .exhausted (exhausted)
    );

    // A set is free only when software has released it and hardware is idle.
    assign set_free = !set_inuse[cur_set] && set_idle[cur_set];
    assign en_row   = slot_enable[int'(cur_set)*SLOTS +: SLOTS];

    req_addr_match #(.ADDR_W(ADDR_W), .MAX_REQ(MAX_REQ)) u_match (
        .probe (rd_addr),
        .reqs  (req_q),
        .req_n (reqn_q),
        .hit   (match)
    );

    assign hit    = pend_q && match;
    assign finish = scanning && (hit || exhausted);
    assign rd_en  = scanning && !exhausted && !set_free && en_row[cur_slot];
    assign rd_set  = cur_set;
    assign rd_slot = cur_slot;

    // Move between idle and scanning.
    always_ff @(posedge clk) begin
        if (!rst_n)      state_q <= ST_IDLE;
        else if (load)   state_q <= ST_SCAN;
        else if (finish) state_q <= ST_IDLE;
    end

    // Hold the request for the whole scan.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= '0;
            reqn_q <= '0;
        end else if (load) begin
            req_q  <= req_addr;
            reqn_q <= req_count;
        end
    end

    // Mark that rd_addr holds a fresh slot value in the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= rd_en && !finish;
    end

    // Produce the done strobe and hold the verdict until the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            busy_q <= 1'b0;
            bad_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept_start && !req_ok) begin
                done_q <= 1'b1;
                busy_q <= 1'b0;
                bad_q  <= 1'b1;
            end else if (finish) begin
                done_q <= 1'b1;
                busy_q <= hit;
                bad_q  <= 1'b0;
            end
        end
    end

    assign done_o = done_q;
    assign busy_o = busy_q;
    assign bad_o  = bad_q;

    // A busy verdict needs a slot value that was read in the cycle before.
    assert_hit_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && busy_o) |-> $past(pend_q));

    // A rejected request never reports a conflict.
    assert_bad_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && bad_o) |-> !busy_o);

    // No reads are issued while idle, so starts there cannot disturb a scan.
    assert_idle_no_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !rd_en);

    // Done follows either a scan cycle or a start seen while idle.
    assert_done_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(state_q) == ST_SCAN || $past(start)));
endmodule

// File: tb/inflight_conflict_check_test.sv
`timescale 1ns/1ps
module inflight_conflict_check_test;
    localparam int NS = 8;
    localparam int SL = 4;
    localparam int AW = 16;
    localparam int MR = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n, start;
    logic [2:0]    g_base;
    logic [3:0]    g_count;
    logic [2:0]    g_n;
    logic [AW-1:0] g_addr [0:MR-1];
    logic [NS-1:0] set_inuse, set_idle;
    logic [NS*SL-1:0] slot_enable;
    logic          rd_en;
    logic [2:0]    rd_set;
    logic [1:0]    rd_slot;
    logic [AW-1:0] rd_addr;
    logic          done_o, busy_o, bad_o;
    logic [AW-1:0] mem [0:NS*SL-1];

    int checks = 0;
    int errors = 0;

    bit         e_rd   [0:63];
    logic [2:0] e_set  [0:63];
    logic [1:0] e_slot [0:63];
    int         e_done;
    bit         e_busy, e_bad;

    inflight_conflict_check #(.NUM_SETS(NS), .SLOTS(SL), .ADDR_W(AW), .MAX_REQ(MR)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .grp_base(g_base), .grp_count(g_count), .req_count(g_n),
        .req_addr({g_addr[3], g_addr[2], g_addr[1], g_addr[0]}),
        .set_inuse(set_inuse), .set_idle(set_idle), .slot_enable(slot_enable),
        .rd_en(rd_en), .rd_set(rd_set), .rd_slot(rd_slot), .rd_addr(rd_addr),
        .done_o(done_o), .busy_o(busy_o), .bad_o(bad_o)
    );

    // Registered slot address store seen by the read port.
    always @(posedge clk) if (rd_en) rd_addr <= mem[int'(rd_set)*SL + int'(rd_slot)];

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit req_has(input logic [AW-1:0] a);
        for (int i = 0; i < int'(g_n); i++) if (g_addr[i] == a) return 1'b1;
        return 1'b0;
    endfunction

    // Behavioural model: walk the group and list what each cycle must show.
    task automatic build_expect();
        int t;
        int hit_t;
        t = 0;
        hit_t = -1;
        for (int k = 0; k < 64; k++) e_rd[k] = 1'b0;
        if (g_n == 0 || int'(g_n) > MR) begin
            e_done = 1; e_busy = 1'b0; e_bad = 1'b1;
            return;
        end
        for (int j = 0; j < int'(g_count); j++) begin
            int s;
            s = (int'(g_base) + j) % NS;
            if (!set_inuse[s] && set_idle[s]) begin
                t++;
            end else begin
                for (int k = 0; k < SL; k++) begin
                    t++;
                    if (slot_enable[s*SL + k]) begin
                        e_rd[t] = 1'b1; e_set[t] = 3'(s); e_slot[t] = 2'(k);
                        if (hit_t < 0 && req_has(mem[s*SL + k])) hit_t = t;
                    end
                end
            end
        end
        e_bad = 1'b0;
        if (hit_t >= 0) begin
            for (int k = hit_t + 2; k < 64; k++) e_rd[k] = 1'b0;
            e_done = hit_t + 2; e_busy = 1'b1;
        end else begin
            e_done = t + 2; e_busy = 1'b0;
        end
    endtask

    // Issue one start and compare every cycle until one past done.
    task automatic run_case(input string tag, input bit inject);
        logic [2:0] saved_n;
        saved_n = g_n;
        build_expect();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int k = 1; k <= e_done; k++) begin
            if (k > 1) @(negedge clk);
            chk(rd_en == e_rd[k] && (!e_rd[k] || (rd_set == e_set[k] && rd_slot == e_slot[k])),
                "R2", $sformatf("%s read cycle %0d", tag, k),
                {rd_en, rd_set, rd_slot}, {e_rd[k], e_set[k], e_slot[k]});
            chk(done_o == (k == e_done), tag, $sformatf("done cycle %0d", k),
                int'(done_o), int'(k == e_done));
            if (k == e_done) begin
                chk(busy_o == e_busy, tag, "busy verdict", int'(busy_o), int'(e_busy));
                chk(bad_o == e_bad, tag, "bad flag", int'(bad_o), int'(e_bad));
            end
            if (inject && k == 2) begin start = 1'b1; g_n = 3'd0; end
            if (inject && k == 3) begin start = 1'b0; g_n = saved_n; end
        end
        start = 1'b0;
        g_n = saved_n;
        @(negedge clk);
        chk(!done_o && !rd_en, "R10", "quiet after done", {done_o, rd_en}, 0);
    endtask

    task automatic set_req(input logic [2:0] n, input logic [AW-1:0] a0, input logic [AW-1:0] a1,
                           input logic [AW-1:0] a2, input logic [AW-1:0] a3);
        g_n = n; g_addr[0] = a0; g_addr[1] = a1; g_addr[2] = a2; g_addr[3] = a3;
    endtask

    function automatic logic [AW-1:0] slot_val(input int s, input int k);
        return mem[s*SL + k];
    endfunction

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < NS*SL; i++) mem[i] = AW'(16'hA000 + i * 16'h0011);
        rd_addr = '0;
        rst_n = 1'b0; start = 1'b0;
        g_base = '0; g_count = '0;
        set_req(3'd1, 16'h1234, 16'h1234, 16'h1234, 16'h1234);
        set_inuse = '1; set_idle = '0; slot_enable = '1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done_o && !busy_o && !bad_o && !rd_en, "R1", "reset outputs",
            {done_o, busy_o, bad_o, rd_en}, 0);

        // All sets free: one cycle each, no reads, accept.
        set_inuse = '0; set_idle = '1;
        g_base = 3'd0; g_count = 4'd4;
        set_req(3'd1, slot_val(1, 0), 16'h1234, 16'h1234, 16'h1234);
        run_case("R4", 1'b0);

        // Busy sets, no stored address matches: accept.
        set_inuse = '1; set_idle = '0;
        g_base = 3'd1; g_count = 4'd3;
        set_req(3'd2, 16'h1234, 16'h5678, 16'h0, 16'h0);
        run_case("R6", 1'b0);

        // Match in the middle of the walk: busy with early stop.
        g_base = 3'd0; g_count = 4'd8;
        set_req(3'd2, 16'h5555, slot_val(3, 2), 16'h0, 16'h0);
        run_case("R5", 1'b0);

        // Matching slot has its enable bit cleared: accept.
        slot_enable = '1; slot_enable[2*SL + 1] = 1'b0;
        set_req(3'd1, slot_val(2, 1), 16'h0, 16'h0, 16'h0);
        run_case("R2", 1'b0);
        slot_enable = '1;

        // Free set holding the address is skipped; other flag mixes are scanned.
        set_req(3'd1, slot_val(5, 0), 16'h0, 16'h0, 16'h0);
        g_base = 3'd4; g_count = 4'd3;
        set_inuse[5] = 1'b0; set_idle[5] = 1'b1;
        run_case("R4", 1'b0);
        set_inuse[5] = 1'b1; set_idle[5] = 1'b1;
        run_case("R4", 1'b0);
        set_inuse[5] = 1'b0; set_idle[5] = 1'b0;
        run_case("R4", 1'b0);
        set_inuse = '1; set_idle = '0;

        // Matching addresses only outside the group: accept.
        g_base = 3'd2; g_count = 4'd2;
        set_req(3'd2, slot_val(6, 1), slot_val(0, 3), 16'h0, 16'h0);
        run_case("R3", 1'b0);

        // Match sits beyond req_count, then inside it.
        g_base = 3'd0; g_count = 4'd4;
        set_req(3'd2, 16'h1111, 16'h2222, slot_val(1, 3), 16'h0);
        run_case("R9", 1'b0);
        g_n = 3'd3;
        run_case("R9", 1'b0);

        // Illegal request counts are rejected at once.
        g_n = 3'd0;
        run_case("R7", 1'b0);
        g_n = 3'd5;
        run_case("R7", 1'b0);

        // Empty group: accept two cycles after start.
        g_count = 4'd0;
        set_req(3'd1, slot_val(0, 0), 16'h0, 16'h0, 16'h0);
        run_case("R6", 1'b0);

        // Start pulse during a scan is ignored.
        g_base = 3'd0; g_count = 4'd8;
        set_req(3'd1, 16'h1234, 16'h0, 16'h0, 16'h0);
        run_case("R8", 1'b1);

        // Match on the very last slot of the group.
        g_base = 3'd6; g_count = 4'd2;
        set_req(3'd4, 16'h0, 16'h1, 16'h2, slot_val(7, 3));
        run_case("R5", 1'b0);

        // Group that wraps past the last set index.
        g_base = 3'd7; g_count = 4'd2;
        set_inuse[7] = 1'b0; set_idle[7] = 1'b1;
        set_req(3'd1, slot_val(0, 2), 16'h0, 16'h0, 16'h0);
        run_case("R2", 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule